// File: doc/BRIEF.md
# Hybrid Linear Cellular Automaton Random Source

This block produces a W-bit pseudorandom state from a one-dimensional row of W cells. Every cell sits at a fixed site and obeys one of two linear XOR rules. The first rule combines only the two neighbours of the cell. The second rule also folds in the cell's own value. A rule-vector parameter picks the rule for each site at elaboration. All cells move forward together on each enabled clock, and each cell reads only its two adjacent cells. With a well-chosen rule vector, the row visits every nonzero W-bit state once before it repeats.

The user loads a seed, then raises the advance enable to step the row. The W-bit state output gives the current cell values. The all-zero state never leaves itself. For that reason, a zero seed is replaced by a nonzero default, and reset also starts the row from that default.

Top module: `ca_hybrid_prng`

## Requirements
- R1: While reset is asserted, and after it is released with no load or advance, the state output equals DEFAULT_SEED (default 4'b0001).
- R2: When load_i is 1 with a nonzero seed_i at a clock edge, state_o equals that seed from that edge on.
- R3: When load_i is 1 with seed_i equal to zero, state_o becomes DEFAULT_SEED, never zero.
- R4: When load_i and adv_i are both 1, the load wins and the automaton does not step.
- R5: When both load_i and adv_i are 0, state_o holds its value.
- R6: A cell whose rule-vector bit is 0 takes the XOR of its west neighbour (the next higher bit) and its east neighbour (the next lower bit). Its own value is not used.
- R7: A cell whose rule-vector bit is 1 takes the XOR of its west neighbour, its own value and its east neighbour.
- R8: The missing neighbours at the ends of the row read as 0: bit W-1 has no west neighbour and bit 0 has no east neighbour.
- R9: With the default W=4 and rule vector 4'b1011, any nonzero state returns to itself after exactly 2^W-1 = 15 advances, and it is never zero along the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_i | input | 1 | Load seed_i into the cells (a zero seed becomes the default) |
| seed_i | input | W | Seed value |
| adv_i | input | 1 | Step every cell once |
| state_o | output | W | Current cell values |

## Verification
Each cell feeds its neighbours on the very next step. A single wrong cell rule or a wrong boundary therefore shows up in state_o one clock after the first advance, and it then spreads outward by one bit per step. The bench compares state_o with a behavioural model on every clock, so such an error is caught at the first divergent edge. It also catches a wrong period or a trap at zero. Faults in the load, zero-seed and hold paths appear on the clock right after the stimulus.

// File: rtl/ca_prng_pkg.sv
package ca_prng_pkg;

  typedef enum logic {
    RULE_90  = 1'b0,
    RULE_150 = 1'b1
  } rule_kind_e;

  function automatic rule_kind_e kind_of(input logic sel);
    return sel ? RULE_150 : RULE_90;
  endfunction

endpackage

// File: rtl/ca_reset_sync.sv
module ca_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ca_seed_guard.sv
module ca_seed_guard #(
  parameter int unsigned       W            = 4,
  parameter logic [W-1:0]      DEFAULT_SEED = {{(W-1){1'b0}}, 1'b1}
) (
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] seed_o
);

  logic seed_is_zero;

  always_comb begin
    seed_is_zero = (seed_i == '0);
    seed_o       = seed_is_zero ? DEFAULT_SEED : seed_i;
  end

endmodule

// File: rtl/ca_cell.sv
module ca_cell
  import ca_prng_pkg::*;
#(
  parameter rule_kind_e KIND = RULE_90
) (
  input  logic west_i,
  input  logic self_i,
  input  logic east_i,
  output logic next_o
);

  logic pair_x;

  always_comb begin
    pair_x = west_i ^ east_i;
  end

  generate
    if (KIND == RULE_150) begin : g_r150
      assign next_o = pair_x ^ self_i;
    end else begin : g_r90
      assign next_o = pair_x;
    end
  endgenerate

endmodule

// File: rtl/ca_hybrid_prng.sv
module ca_hybrid_prng
  import ca_prng_pkg::*;
#(
  parameter int unsigned  W            = 4,
  parameter logic [W-1:0] RULE_VEC     = 4'b1011,
  parameter logic [W-1:0] DEFAULT_SEED = {{(W-1){1'b0}}, 1'b1}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);

  localparam int unsigned LAST = W - 1;

  logic         rst_sync_n;
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic [W-1:0] step_val;
  logic [W-1:0] clean_seed;
  logic [W+1:0] padded;
  logic         state_en;

  ca_reset_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ca_seed_guard #(
    .W            (W),
    .DEFAULT_SEED (DEFAULT_SEED)
  ) i_seed_guard (
    .seed_i (seed_i),
    .seed_o (clean_seed)
  );

  // Null boundary: one zero pad cell on each side of the row.
  assign padded = {1'b0, state_q, 1'b0};

  generate
    for (genvar i = 0; i < W; i++) begin : g_site
      ca_cell #(
        .KIND (kind_of(RULE_VEC[i]))
      ) i_cell (
        .west_i (padded[i+2]),
        .self_i (padded[i+1]),
        .east_i (padded[i]),
        .next_o (step_val[i])
      );
    end
  endgenerate

  always_comb begin
    state_en = load_i | adv_i;
    state_d  = state_q;
    if (load_i) begin
      state_d = clean_seed;
    end else if (adv_i) begin
      state_d = step_val;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= DEFAULT_SEED;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_i && (seed_i != '0)) |=> (state_o == $past(seed_i))); // R2

  AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_i && (seed_i == '0)) |=> (state_o == DEFAULT_SEED) && (state_o != '0)); // R3

  AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_i && adv_i && (seed_i != '0)) |=> (state_o == $past(seed_i))); // R4

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_i && !adv_i) |=> $stable(state_o)); // R5

  AST_TOP_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_i && adv_i && !RULE_VEC[LAST]) |=> (state_o[LAST] == $past(state_o[LAST-1]))); // R8

endmodule

// File: tb/test_ca_hybrid_prng.sv
`timescale 1ns/1ps
module test_ca_hybrid_prng;

  localparam int W = 4;
  localparam logic [W-1:0] RULES = 4'b1011;
  localparam logic [W-1:0] DEF = 4'b0001;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_i;
  logic [W-1:0] seed_i;
  logic         adv_i;
  logic [W-1:0] state_o;

  int errors = 0;
  int checks = 0;
  int model;
  bit done = 0;

  always #2.5 clk = ~clk;

  ca_hybrid_prng #(.W(W), .RULE_VEC(RULES), .DEFAULT_SEED(DEF)) i_ca_hybrid_prng (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .seed_i  (seed_i),
    .adv_i   (adv_i),
    .state_o (state_o)
  );

  function automatic int next_state(input int s);
    int r = 0;
    for (int i = 0; i < W; i++) begin
      int wv = (i + 1 < W) ? ((s >> (i + 1)) & 1) : 0;
      int ev = (i > 0) ? ((s >> (i - 1)) & 1) : 0;
      int sv = RULES[i] ? ((s >> i) & 1) : 0;
      r |= ((wv ^ ev ^ sv) & 1) << i;
    end
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at negedge, model updates with the edge, compare at next negedge.
  task automatic cyc(input logic ld, input logic [W-1:0] sd, input logic adv, input string req);
    load_i = ld;
    seed_i = sd;
    adv_i  = adv;
    @(posedge clk);
    if (ld) model = (sd == 0) ? int'(DEF) : int'(sd);
    else if (adv) model = next_state(model);
    @(negedge clk);
    check(req, int'(state_o), model);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int count;
    bit saw_zero;
    rst_n  = 1'b0;
    load_i = 1'b0;
    seed_i = '0;
    adv_i  = 1'b0;
    model  = int'(DEF);
    repeat (3) @(negedge clk);
    check("R1 in reset", int'(state_o), int'(DEF));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", int'(state_o), int'(DEF));

    cyc(1'b1, 4'b0001, 1'b0, "R2 load 0001");
    cyc(1'b0, 4'b0000, 1'b1, "R7 rule150 step 0001->0011");
    check("R7 hand value", int'(state_o), 4'b0011);
    cyc(1'b1, 4'b1000, 1'b0, "R2 load 1000");
    cyc(1'b0, 4'b0000, 1'b1, "R6/R8 step 1000->1100");
    check("R6 R8 hand value", int'(state_o), 4'b1100);
    cyc(1'b1, 4'b0100, 1'b0, "R2 load 0100");
    cyc(1'b0, 4'b0000, 1'b1, "R6 step 0100->1010");
    check("R6 hand value", int'(state_o), 4'b1010);

    cyc(1'b0, 4'b0000, 1'b0, "R5 hold");
    cyc(1'b0, 4'b1111, 1'b0, "R5 hold seed ignored");
    cyc(1'b1, 4'b0000, 1'b0, "R3 zero seed");
    cyc(1'b1, 4'b0110, 1'b1, "R4 load beats advance");
    check("R4 value", int'(state_o), 4'b0110);
    cyc(1'b1, 4'b0000, 1'b1, "R3 R4 zero seed with advance");

    for (int s = 1; s < (1 << W); s += 6) begin
      cyc(1'b1, s[W-1:0], 1'b0, "R2 period seed");
      count = 0;
      saw_zero = 0;
      do begin
        cyc(1'b0, 4'b0000, 1'b1, "R9 sequence");
        count++;
        if (state_o == '0) saw_zero = 1;
      end while (int'(state_o) != s && count < 40);
      check("R9 period", count, (1 << W) - 1);
      check("R9 never zero", int'(saw_zero), 0);
      $display("Period from seed %0h: %0d (maximal=%0d)", s, count, (count == (1 << W) - 1));
    end

    for (int k = 0; k < 20; k++) begin
      cyc(1'b0, 4'b0000, (k % 3) != 0, "R5 R9 mixed advance");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule